// File: doc/BRIEF.md
# Split-Word RAM with Extension Register

This block is a single-port word memory, 2048 entries of 32 bits, that is used from two sides. A program port fetches whole 32-bit words. A data port is only 20 bits wide. A 12-bit extension register makes up the missing width.

On a data-side store, the register supplies the top 12 bits and the bus supplies the bottom 20. On a data-side load, the bottom 20 bits go back on the bus, and the top 12 bits are latched into the register as a side effect. Software can also write and read the register directly, so it can prepare or pick up the top bits.

Each port is a stream pair: a request channel and a response channel, each with valid/ready. A request is taken on a clock edge where valid and ready are both high.
- A request channel's ready is high whenever its response slot is empty, or whenever the slot is being drained in the same cycle.
- A response stays valid, with its data held unchanged, until the consumer raises ready.
- Writes to the memory or to the register produce no response.

Both ports can be served in the same cycle. The program access is ordered before the data access.

Top module: `xword_ram`

## Requirements
- R1: A data request with op code 2'b01 (memory store) writes the word {extension register[11:0], wdata[19:0]} to the addressed entry, and a later program fetch of that entry returns exactly this 32-bit word.
- R2: A data request with op code 2'b00 (memory load) that is accepted on edge t gives a response that is valid after edge t and carries bits [19:0] of the addressed word.
- R3: A memory load replaces the extension register with bits [31:20] of the word that was read.
- R4: Op code 2'b11 (register write) loads the register from wdata[11:0]. Op code 2'b10 (register read) responds with {8'h00, register[11:0]}, so bits [19:12] are always zero.
- R5: A program fetch returns all 32 bits of the addressed word one cycle after it is accepted, and it leaves the extension register unchanged.
- R6: When a program fetch and a data store to the same address are accepted on the same edge, the fetch returns the word as it was before the store.
- R7: A register write accepted on the edge that directly follows a memory load's acceptance is discarded. The register then holds the loaded top bits.
- R8: A register read or a memory store accepted on the edge that directly follows a memory load uses the newly loaded top bits.
- R9: While a response is valid and its ready is low, the response stays valid with stable data, and the matching request ready is low.
- R10: After reset, no response is valid, both request readies are high, and the extension register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req_valid | input | 1 | Program fetch request valid |
| p_req_ready | output | 1 | Program fetch request ready |
| p_req_addr | input | 11 | Program fetch word address |
| p_rsp_valid | output | 1 | Program fetch response valid |
| p_rsp_ready | input | 1 | Program fetch response ready |
| p_rsp_word | output | 32 | Fetched 32-bit word |
| d_req_valid | input | 1 | Data request valid |
| d_req_ready | output | 1 | Data request ready |
| d_req_op | input | 2 | 00 load, 01 store, 10 register read, 11 register write |
| d_req_addr | input | 11 | Data word address |
| d_req_wdata | input | 20 | Store data, or register data in [11:0] |
| d_rsp_valid | output | 1 | Data response valid |
| d_rsp_ready | input | 1 | Data response ready |
| d_rsp_data | output | 20 | Loaded low bits or zero-extended register |

## Verification
The assertions check on every cycle:
- that a held response keeps its valid and its data while it is stalled;
- that the extension register never changes without a load or a write;
- that a load which coincides with a direct write always prevails;
- that a register-read response has its upper bits zero;
- that a load and a store are never issued together.

Only the bench scenarios can show the value behaviour. These cover the packing of 12 and 20 bits into stored words, fetches that see the pre-store word on a shared cycle, and reads and stores that follow a load immediately and see the forwarded top bits. They also cover the expected words across a mixed random stream of all four data operations alongside fetches.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    OP_MEM_LOAD  = 2'b00,
    OP_MEM_STORE = 2'b01,
    OP_XREG_RD   = 2'b10,
    OP_XREG_WR   = 2'b11
  } xw_op_e;
endpackage

// File: rtl/xw_core.sv
module xw_core #(
  parameter int DEPTH  = 2048,
  parameter int WORD_W = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_re,
  input  logic [AW-1:0]     p_addr,
  output logic [WORD_W-1:0] p_rdata,
  input  logic              d_re,
  input  logic              d_we,
  input  logic [AW-1:0]     d_addr,
  input  logic [WORD_W-1:0] d_wdata,
  output logic [WORD_W-1:0] d_rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Two slots share the one array port within a cycle: the program slot
  // samples the array first, so it observes contents before the data slot.
  always_ff @(posedge clk) begin
    if (p_re) p_rdata <= mem[p_addr];
    if (d_we) mem[d_addr] <= d_wdata;
    else if (d_re) d_rdata <= mem[d_addr];
  end

  AST_ONE_DATA_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_re && d_we)); // R2
endmodule

// File: rtl/xw_ext_reg.sv
module xw_ext_reg #(
  parameter int EXT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [EXT_W-1:0] load_val,
  input  logic             wr_en,
  input  logic [EXT_W-1:0] wr_val,
  output logic [EXT_W-1:0] xreg_q,
  output logic [EXT_W-1:0] xreg_view
);
  // The value from memory is forwarded so that accesses in the same cycle
  // already see the loaded bits.
  assign xreg_view = load_en ? load_val : xreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       xreg_q <= '0;
    else if (load_en) xreg_q <= load_val;
    else if (wr_en)   xreg_q <= wr_val;
  end

  AST_LOAD_PREVAILS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> xreg_q == $past(load_val)); // R7
  AST_XREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !wr_en) |=> $stable(xreg_q)); // R5
endmodule

// File: rtl/xw_rsp_slot.sv
module xw_rsp_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic makes_rsp,
  output logic accept,
  output logic rsp_valid,
  input  logic rsp_ready
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rsp_valid <= 1'b0;
    else if (accept && makes_rsp)    rsp_valid <= 1'b1;
    else if (rsp_ready)              rsp_valid <= 1'b0;
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid); // R9
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && makes_rsp) |=> rsp_valid); // R2
  AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !accept); // R9
endmodule

// File: rtl/xword_ram.sv
module xword_ram
  import xw_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int WORD_W = 32,
  parameter int BUS_W  = 20,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_req_valid,
  output logic              p_req_ready,
  input  logic [AW-1:0]     p_req_addr,
  output logic              p_rsp_valid,
  input  logic              p_rsp_ready,
  output logic [WORD_W-1:0] p_rsp_word,
  input  logic              d_req_valid,
  output logic              d_req_ready,
  input  logic [1:0]        d_req_op,
  input  logic [AW-1:0]     d_req_addr,
  input  logic [BUS_W-1:0]  d_req_wdata,
  output logic              d_rsp_valid,
  input  logic              d_rsp_ready,
  output logic [BUS_W-1:0]  d_rsp_data
);
  localparam int EXT_W = WORD_W - BUS_W;
  localparam int PAD_W = BUS_W - EXT_W;

  xw_op_e             op;
  logic               p_acc, d_acc;
  logic               mem_load, mem_store, x_rd, x_wr;
  logic               load_pend_q, src_mem_q;
  logic [EXT_W-1:0]   x_q, x_view;
  logic [BUS_W-1:0]   x_rsp_q;
  logic [WORD_W-1:0]  d_rdata;

  assign op        = xw_op_e'(d_req_op);
  assign mem_load  = d_acc && (op == OP_MEM_LOAD);
  assign mem_store = d_acc && (op == OP_MEM_STORE);
  assign x_rd      = d_acc && (op == OP_XREG_RD);
  assign x_wr      = d_acc && (op == OP_XREG_WR);

  xw_rsp_slot u_pslot (
    .clk(clk), .rst_n(rst_n), .req_valid(p_req_valid), .req_ready(p_req_ready),
    .makes_rsp(1'b1), .accept(p_acc), .rsp_valid(p_rsp_valid), .rsp_ready(p_rsp_ready)
  );

  xw_rsp_slot u_dslot (
    .clk(clk), .rst_n(rst_n), .req_valid(d_req_valid), .req_ready(d_req_ready),
    .makes_rsp(d_req_op == OP_MEM_LOAD || d_req_op == OP_XREG_RD), .accept(d_acc),
    .rsp_valid(d_rsp_valid), .rsp_ready(d_rsp_ready)
  );

  xw_core #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .p_re(p_acc), .p_addr(p_req_addr), .p_rdata(p_rsp_word),
    .d_re(mem_load), .d_we(mem_store), .d_addr(d_req_addr),
    .d_wdata({x_view, d_req_wdata}), .d_rdata(d_rdata)
  );

  xw_ext_reg #(.EXT_W(EXT_W)) u_xreg (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_pend_q), .load_val(d_rdata[WORD_W-1:BUS_W]),
    .wr_en(x_wr), .wr_val(d_req_wdata[EXT_W-1:0]),
    .xreg_q(x_q), .xreg_view(x_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend_q <= 1'b0;
      src_mem_q   <= 1'b0;
      x_rsp_q     <= '0;
    end else begin
      load_pend_q <= mem_load;
      if (mem_load || x_rd) src_mem_q <= mem_load;
      if (x_rd) x_rsp_q <= {{PAD_W{1'b0}}, x_view};
    end
  end

  assign d_rsp_data = src_mem_q ? d_rdata[BUS_W-1:0] : x_rsp_q;

  AST_DRSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rsp_valid && !d_rsp_ready) |=> $stable(d_rsp_data)); // R9
  AST_PRSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rsp_valid && !p_rsp_ready) |=> $stable(p_rsp_word)); // R9
  AST_XRD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rsp_valid && !src_mem_q) |-> (d_rsp_data[BUS_W-1:EXT_W] == '0)); // R4
  AST_FETCH_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (p_acc && !d_acc && !load_pend_q) |=> $stable(x_q)); // R5
endmodule

// File: tb/tb_xword_ram.sv
module tb_xword_ram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p_req_valid = 1'b0, p_rsp_ready = 1'b1;
  logic [10:0] p_req_addr = '0;
  logic        p_req_ready, p_rsp_valid;
  logic [31:0] p_rsp_word;
  logic        d_req_valid = 1'b0, d_rsp_ready = 1'b1;
  logic [1:0]  d_req_op = '0;
  logic [10:0] d_req_addr = '0;
  logic [19:0] d_req_wdata = '0;
  logic        d_req_ready, d_rsp_valid;
  logic [19:0] d_rsp_data;

  xword_ram dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mem_m [int];
  logic [11:0] x_m = '0;
  bit          prev_load = 1'b0;
  logic [19:0] dq[$];
  string       dtag[$];
  logic [31:0] pq[$];
  string       ptag[$];

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expectations pushed into the scoreboard.
  task automatic cyc(bit dv, logic [1:0] op, logic [10:0] a, logic [19:0] wd,
                     bit pv, logic [10:0] pa, string tag);
    @(negedge clk);
    d_req_valid = dv; d_req_op = op; d_req_addr = a; d_req_wdata = wd;
    p_req_valid = pv; p_req_addr = pa;
    if (pv) begin pq.push_back(mem_m[int'(pa)]); ptag.push_back(tag); end
    if (dv) begin
      case (op)
        2'b00: begin
          dq.push_back(mem_m[int'(a)][19:0]); dtag.push_back(tag);
          x_m = mem_m[int'(a)][31:20];
        end
        2'b01: mem_m[int'(a)] = {x_m, wd};
        2'b10: begin dq.push_back({8'h00, x_m}); dtag.push_back(tag); end
        default: if (!prev_load) x_m = wd[11:0];
      endcase
    end
    prev_load = dv && (op == 2'b00);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, '0, '0, 1'b0, '0, "idle");
  endtask

  // Monitor: pops and compares as responses are handed over.
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && d_rsp_valid && d_rsp_ready) begin
      if (dq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected data response %h expected none", d_rsp_data);
      end else begin
        string t;
        logic [19:0] e;
        t = dtag.pop_front(); e = dq.pop_front();
        chk(t, {12'h0, d_rsp_data}, {12'h0, e});
      end
    end
    if (rst_n && p_rsp_valid && p_rsp_ready) begin
      if (pq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected fetch response %h expected none", p_rsp_word);
      end else begin
        string t;
        logic [31:0] e;
        t = ptag.pop_front(); e = pq.pop_front();
        chk(t, p_rsp_word, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R10 rsp valid", {30'h0, d_rsp_valid, p_rsp_valid}, 32'h0);
    chk("R10 ready", {30'h0, d_req_ready, p_req_ready}, 32'h3);
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R10 xreg zero");
    // R4 register write and zero-extended read
    cyc(1'b1, 2'b11, '0, 20'h00ABC, 1'b0, '0, "R4");
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R4 read");
    cyc(1'b1, 2'b11, '0, 20'hFFFFF, 1'b0, '0, "R4");
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R4 upper zero");
    // R1 stores packed with register bits, fetched whole
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, 2'b11, '0, 20'(i * 13 + 7), 1'b0, '0, "R1 set");
      cyc(1'b1, 2'b01, 11'(i), 20'(32'h5A5A5 ^ (i * 32'h1111)), 1'b0, '0, "R1");
    end
    cyc(1'b1, 2'b11, '0, 20'h00321, 1'b0, '0, "R1 set");
    cyc(1'b1, 2'b01, 11'd2047, 20'h80001, 1'b0, '0, "R1 top");
    for (int i = 0; i < 16; i++) cyc(1'b0, 2'b00, '0, '0, 1'b1, 11'(i), "R1 fetch");
    cyc(1'b0, 2'b00, '0, '0, 1'b1, 11'd2047, "R1 fetch top");
    // R2 R3 load, R8 read right after
    cyc(1'b1, 2'b00, 11'd5, '0, 1'b0, '0, "R2 load");
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R8 R3 xreg after load");
    idle(1);
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R3 xreg later");
    // R5 fetch leaves register alone
    cyc(1'b1, 2'b11, '0, 20'h00777, 1'b0, '0, "R5 set");
    cyc(1'b0, 2'b00, '0, '0, 1'b1, 11'd9, "R5 fetch");
    cyc(1'b0, 2'b00, '0, '0, 1'b1, 11'd3, "R5 fetch");
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R5 xreg kept");
    // R6 fetch and store to same address on one edge
    cyc(1'b1, 2'b01, 11'd7, 20'h12345, 1'b1, 11'd7, "R6 old word");
    cyc(1'b0, 2'b00, '0, '0, 1'b1, 11'd7, "R6 new word");
    // R7 register write right after a load is dropped
    cyc(1'b1, 2'b00, 11'd11, '0, 1'b0, '0, "R7 load");
    cyc(1'b1, 2'b11, '0, 20'h00DDD, 1'b0, '0, "R7 write");
    cyc(1'b1, 2'b10, '0, '0, 1'b0, '0, "R7 load wins");
    // R8 store right after a load uses loaded bits
    cyc(1'b1, 2'b00, 11'd12, '0, 1'b0, '0, "R8 load");
    cyc(1'b1, 2'b01, 11'd20, 20'h0F0F0, 1'b0, '0, "R8 store");
    cyc(1'b0, 2'b00, '0, '0, 1'b1, 11'd20, "R8 fetch");
    idle(2);
    // R9 back-pressure on the data response
    @(negedge clk); d_rsp_ready = 1'b0;
    cyc(1'b1, 2'b00, 11'd4, '0, 1'b0, '0, "R9 held load");
    idle(1);
    #(CLK_PERIOD/4);
    chk("R9 ready low", {31'h0, d_req_ready}, 32'h0);
    chk("R9 valid held", {31'h0, d_rsp_valid}, 32'h1);
    chk("R9 data", {12'h0, d_rsp_data}, {12'h0, mem_m[4][19:0]});
    @(negedge clk); #(CLK_PERIOD/4);
    chk("R9 still held", {12'h0, d_rsp_data}, {12'h0, mem_m[4][19:0]});
    @(negedge clk); d_rsp_ready = 1'b1;
    idle(2);
    // mixed stream over all operations
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      cyc($urandom_range(0, 3) != 0, op, 11'($urandom_range(0, 15)),
          20'($urandom), $urandom_range(0, 1) == 1, 11'($urandom_range(0, 15)),
          "R1 R2 R3 R8 mixed");
    end
    idle(4);
    chk("R2 queues drained", dq.size() + pq.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule